// File: doc/BRIEF.md
# Single-Line Pulse-Width Digit Sequencer

This block drives the digit-select lines of a multiplexed display from one serial control line. The line rests low. Each narrow high pulse moves a small position counter on by one place. A binary-to-one-hot decoder turns the count into the select outputs, so exactly one digit is enabled at any moment.

Noise or an electrostatic upset can knock the counter out of step with the controller. To recover, the controller holds the line high for longer than a configured threshold. The block reads that long level as a resync command and returns the counter to position zero. This works at any time, not only after power-up.

The line is brought into the local clock domain first. The block then measures pulse widths in local clock cycles:
- Pulses shorter than a minimum width are dropped as glitches.
- Pulses of medium width count as steps.
- Pulses at or above the long threshold count as resync.

Top module: `pulse_digit_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the position and the high-time measurement are cleared. After reset `digit_idx` is 0 and `digit_sel` has only bit 0 set, with no command needed on the line.
- R2: `digit_sel` is 2**POS_W bits wide (8 by default). Exactly one bit is set: bit number `digit_idx`.
- R3: A high pulse lasting W local clock cycles, with MIN_CYCLES <= W < LONG_CYCLES, adds one to `digit_idx`. The update happens after the pulse ends. Defaults: MIN_CYCLES = 2, LONG_CYCLES = 16.
- R4: A high pulse shorter than MIN_CYCLES leaves `digit_idx` unchanged.
- R5: A high level lasting LONG_CYCLES cycles or more sets `digit_idx` to 0. It issues that reset once per high period, and it never also advances the position when it ends. This holds at any point in operation.
- R6: From position 2**POS_W-1 (7 by default), the next valid short pulse wraps `digit_idx` to 0.
- R7: If `rst` is high in the same cycle that a completed short pulse would advance the position, the reset wins and `digit_idx` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Active-high synchronous reset |
| line_in | input | 1 | Asynchronous serial control line, idles low |
| digit_sel | output | 2**POS_W | One-hot digit select |
| digit_idx | output | POS_W | Current digit position |

## Verification
Two updates can fall in one cycle: the step produced when a short pulse ends, and a synchronous reset. The bench reaches that cycle by counting the synchroniser stages from the falling edge of a three-cycle pulse. It raises `rst` only for the clock edge at which the step would land. The check is judged at the ports: the position must read 0, not the incremented value. The pulse widths in the bench sit just below the glitch limit, at it, just below the long threshold and exactly at it, so that an off-by-one in the width compare moves the observed position.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   // Command decoded from one measured high period of the control line
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_STEP   = 2'd1,
      EV_RESYNC = 2'd2
   } dsq_event_e;

   function automatic int dsq_width(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);

   initial begin
      assert (STAGES >= 2) else $error("dsq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= 1'b0;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/dsq_width_meas.sv
module dsq_width_meas
   import dsq_pkg::*;
#(
   parameter int LONG_CYCLES = 16,
   parameter int MIN_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       line_s,
   output dsq_event_e evt
);

   localparam int HW = dsq_width(LONG_CYCLES);
   localparam logic [HW-1:0] LONG_V = HW'(LONG_CYCLES);
   localparam logic [HW-1:0] MIN_V  = HW'(MIN_CYCLES);
   localparam logic [HW-1:0] LAST_V = HW'(LONG_CYCLES - 1);

   initial begin
      assert (MIN_CYCLES >= 1) else $error("dsq_width_meas: MIN_CYCLES must be >= 1");
      assert (LONG_CYCLES > MIN_CYCLES) else $error("dsq_width_meas: LONG_CYCLES must exceed MIN_CYCLES");
   end

   // Cycles the synchronised line has been high, saturating at LONG_CYCLES
   logic [HW-1:0] hcnt;

   always_ff @(posedge clk) begin
      if (rst)              hcnt <= '0;
      else if (!line_s)     hcnt <= '0;
      else if (hcnt != LONG_V) hcnt <= hcnt + 1'b1;
   end

   // Resync issues while the high level reaches the threshold. A step issues
   // in the first low cycle after a high period of qualifying width.
   always_comb begin
      evt = EV_NONE;
      if (line_s && (hcnt == LAST_V))
         evt = EV_RESYNC;
      else if (!line_s && (hcnt >= MIN_V) && (hcnt < LONG_V))
         evt = EV_STEP;
   end

   // R5: one resync per high period
   a_r5_single_resync: assert property (@(posedge clk) disable iff (rst)
      (evt == EV_RESYNC) |=> (evt != EV_RESYNC));

   // R1: measurement never runs beyond its saturation point
   a_r1_hcnt_bound: assert property (@(posedge clk) disable iff (rst)
      hcnt <= LONG_V);

   // R3: a step only follows a cycle in which the line was high
   a_r3_step_after_high: assert property (@(posedge clk) disable iff (rst)
      (evt == EV_STEP) |-> $past(line_s));

   // R5: once saturated, the end of the high period yields no step
   a_r5_no_step_after_long: assert property (@(posedge clk) disable iff (rst)
      (line_s && hcnt == LONG_V) |=> (evt != EV_STEP));

endmodule

// File: rtl/dsq_pos_ctr.sv
module dsq_pos_ctr
   import dsq_pkg::*;
#(
   parameter int POS_W = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  dsq_event_e              evt,
   output logic [POS_W-1:0]        pos,
   output logic [(1<<POS_W)-1:0]   sel
);

   localparam int NSEL = 1 << POS_W;

   initial begin
      assert (POS_W >= 1 && POS_W <= 8) else $error("dsq_pos_ctr: POS_W out of range");
   end

   // Reset has priority over any command from the line
   always_ff @(posedge clk) begin
      if (rst)                     pos <= '0;
      else if (evt == EV_RESYNC)   pos <= '0;
      else if (evt == EV_STEP)     pos <= pos + 1'b1;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSEL; gi++) begin : g_dec
         assign sel[gi] = (pos == POS_W'(gi));
      end
   endgenerate

   // R2: exactly one select active
   a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
      $countones(sel) == 1);

   // R3 / R6: a step adds one, wrapping at the top
   a_r3_step_inc: assert property (@(posedge clk) disable iff (rst)
      (evt == EV_STEP) |=> (pos == $past(pos) + 1'b1));

   // R5: resync returns to position zero
   a_r5_resync_zero: assert property (@(posedge clk) disable iff (rst)
      (evt == EV_RESYNC) |=> (pos == '0));

   // R4: without a command the position holds
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (evt == EV_NONE) |=> $stable(pos));

   // R7: reset overrides a concurrent step
   a_r7_rst_wins: assert property (@(posedge clk)
      rst |=> (pos == '0));

endmodule

// File: rtl/pulse_digit_seq.sv
module pulse_digit_seq
   import dsq_pkg::*;
#(
   parameter int POS_W       = 3,
   parameter int LONG_CYCLES = 16,
   parameter int MIN_CYCLES  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    line_in,
   output logic [(1<<POS_W)-1:0]   digit_sel,
   output logic [POS_W-1:0]        digit_idx
);

   logic       line_s;
   dsq_event_e evt;

   dsq_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (line_in),
      .q_sync  (line_s)
   );

   dsq_width_meas #(
      .LONG_CYCLES (LONG_CYCLES),
      .MIN_CYCLES  (MIN_CYCLES)
   ) u_meas (
      .clk    (clk),
      .rst    (rst),
      .line_s (line_s),
      .evt    (evt)
   );

   dsq_pos_ctr #(
      .POS_W (POS_W)
   ) u_pos (
      .clk (clk),
      .rst (rst),
      .evt (evt),
      .pos (digit_idx),
      .sel (digit_sel)
   );

   // R2: select output tracks the reported position
   a_r2_sel_matches_idx: assert property (@(posedge clk) disable iff (rst)
      digit_sel[digit_idx] == 1'b1);

endmodule

// File: tb/tb_pulse_digit_seq.sv
`timescale 1ns/1ps
module tb_pulse_digit_seq;

   localparam int POS_W = 3;
   localparam int NSEL  = 1 << POS_W;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            line_in = 1'b0;
   logic [NSEL-1:0] digit_sel;
   logic [POS_W-1:0] digit_idx;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   pulse_digit_seq #(
      .POS_W (POS_W), .LONG_CYCLES (16), .MIN_CYCLES (2), .SYNC_STAGES (2)
   ) dut (
      .clk (clk), .rst (rst), .line_in (line_in),
      .digit_sel (digit_sel), .digit_idx (digit_idx)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_pos(input string req, input int exp);
      check(req, int'(digit_idx), exp);
      check("R2", int'(digit_sel), 1 << exp);
   endtask

   // High for w sampling edges, then idle long enough for the update to land
   task automatic pulse(input int w);
      line_in = 1'b1;
      repeat (w) @(negedge clk);
      line_in = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   // Widths and expected positions, applied in order from reset
   localparam int NV = 8;
   localparam int VW  [NV] = '{3, 1, 2, 15, 16, 4, 40, 0};
   localparam int VEX [NV] = '{1, 1, 2, 3,  0,  1, 0,  0};
   // entries: R3, R4, R3 (min), R3 (long-1), R5 (exact), R3, R5 (very long), idle

   initial begin : watchdog
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: state straight out of reset
      check_pos("R1", 0);
      rst = 1'b0;
      @(negedge clk);
      check_pos("R1", 0);

      for (int i = 0; i < NV; i++) begin
         if (VW[i] > 0) pulse(VW[i]);
         else repeat (4) @(negedge clk);
         check_pos($sformatf("R%0d", (VW[i] >= 16) ? 5 : (VW[i] < 2 && VW[i] > 0) ? 4 : 3), VEX[i]);
      end

      // R6: wrap from top position
      do_reset();
      for (int k = 0; k < NSEL - 1; k++) pulse(3);
      check_pos("R6", NSEL - 1);
      pulse(3);
      check_pos("R6", 0);

      // R5: resync mid-sequence, no step at its end, then stepping resumes
      pulse(5); pulse(5); pulse(5);
      check_pos("R3", 3);
      pulse(20);
      check_pos("R5", 0);
      pulse(2);
      check_pos("R5", 1);

      // R4: a run of glitches changes nothing
      for (int k = 0; k < 4; k++) pulse(1);
      check_pos("R4", 1);

      // R7: reset lands on the same edge as a step
      do_reset();
      pulse(3); pulse(3);
      check_pos("R7", 2);
      line_in = 1'b1;
      repeat (3) @(negedge clk);
      line_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check_pos("R7", 0);

      // R1: reset mid-sequence clears position
      pulse(3);
      check_pos("R3", 1);
      do_reset();
      check_pos("R1", 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule